// File: doc/BRIEF.md
# Interleaved Dual-Lane SEC-DED Byte Memory

This block is a small synchronous single-port byte memory that protects every stored byte against soft errors. On a write, the byte is split into a low nibble and a high nibble. Each nibble is encoded on its own into an 8-bit extended Hamming codeword, which corrects one flipped bit and detects two. The bits of the two codewords are then woven together, so that neighbouring cells of the 16-bit stored word always belong to different codewords. An upset that hits two adjacent cells therefore shows up as one correctable error in each codeword, not as an uncorrectable pair in one of them.

On a read, the stored word is unwoven and both codewords are decoded. A single error in a codeword is repaired on the way out. The decoder reports whether any repair was made and whether either codeword holds an error it cannot repair. Repaired data is never written back to the array, so an error stays in the array until that location is written again. A fault-injection port XORs a mask into one stored word, which lets a test place upsets at chosen cells. The code does not cover the address path: a write that lands at the wrong location goes unnoticed.

The port has no back-pressure. It accepts one access in every cycle, and read data comes back after a fixed latency with a one-cycle valid strobe that cannot be stalled.

Top module: `ecc_ilv_mem`

## Requirements
- R1: When `ce`=1 and `we`=0 in a cycle, `dout` shows the byte stored at `addr` after the next clock edge and `rvalid` is 1 for that one cycle. With no upsets in the array, `dout` equals the last byte written there and both flags are 0.
- R2: A codeword holds 8 bits. Bit 0 is the parity over bits 1..7, chosen so the whole codeword has even parity. Bits 1, 2 and 4 are Hamming checks. Data bits d0..d3 sit at bits 3, 5, 6 and 7. Check bit 1 covers bits 3, 5 and 7. Check bit 2 covers bits 3, 6 and 7. Check bit 4 covers bits 5, 6 and 7. Lane 0 (the low nibble of `din`) occupies the even bits of the stored word: stored bit 2k is lane 0 bit k. Lane 1 (the high nibble) occupies the odd bits: stored bit 2k+1 is lane 1 bit k.
- R3: If any single stored bit is flipped, the read returns the written byte with `err_corrected`=1 and `err_uncorrectable`=0.
- R4: If two adjacent stored bits (2k and 2k+1, or 2k+1 and 2k+2) are flipped, the read returns the written byte with `err_uncorrectable`=0.
- R5: If two bits of the same codeword are flipped, `err_uncorrectable`=1. That lane's nibble is the uncorrected data bits (codeword bits 7, 6, 5 and 3). If the other lane is clean, `err_corrected`=0.
- R6: If only a codeword's overall parity bit (bit 0) is flipped, the data is correct and `err_corrected`=1.
- R7: Corrections are not written back. Reading the same location again after a repair reports `err_corrected`=1 again.
- R8: In a cycle that is not a read, the cycle that follows has `rvalid`=0, and `dout` and both flags keep their values.
- R9: After reset, every location reads 0x00 with both flags 0, and `rvalid`, `dout` and both flags are 0 before the first read.
- R10: When `inj_en`=1, `inj_mask` is XORed into the word at `inj_addr`. If a write to the same address happens in the same cycle, the mask is applied to the newly written word.
- R11: A write attempted while `ce`=0 leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears array and read path |
| ce | input | 1 | Access enable |
| we | input | 1 | 1 = write, 0 = read (when `ce`=1) |
| addr | input | AW ($clog2(DEPTH)) | Word address |
| din | input | 4*LANES | Write byte |
| dout | output | 4*LANES | Read byte after correction |
| rvalid | output | 1 | One-cycle strobe: `dout` and flags hold a fresh read |
| err_corrected | output | 1 | At least one lane had a repaired single error |
| err_uncorrectable | output | 1 | At least one lane had a double error |
| inj_en | input | 1 | Apply fault mask this cycle |
| inj_addr | input | AW | Word that receives the fault mask |
| inj_mask | input | 8*LANES | Bits to flip in the stored word |

## Verification
A fault in the weave or in a check equation does not show up on clean reads. It shows up on the first read of a word that holds an injected flip: the wrong bit gets repaired, or the wrong flag comes up, one cycle after that read is issued. For this reason every stored bit position and every adjacent pair is flipped one at a time, and every double within a lane is flipped as well. A read-path or hold fault shows up as a `dout` or flag change, or as a stray `rvalid`, in the cycle right after a non-read.

// File: rtl/ecc_ilv_pkg.sv
package ecc_ilv_pkg;
  localparam int NIB_W = 4;
  localparam int CW_W  = 8;
  localparam int SYN_W = 3;
  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [CW_W-1:0]  cw_t;
  typedef logic [SYN_W-1:0] syn_t;
endpackage

// File: rtl/ecc_ilv_enc.sv
module ecc_ilv_enc
  import ecc_ilv_pkg::*;
(
  input  nib_t nib,
  output cw_t  cw
);
  cw_t body;
  always_comb begin
    body    = '0;
    body[3] = nib[0];
    body[5] = nib[1];
    body[6] = nib[2];
    body[7] = nib[3];
    body[1] = nib[0] ^ nib[1] ^ nib[3];
    body[2] = nib[0] ^ nib[2] ^ nib[3];
    body[4] = nib[1] ^ nib[2] ^ nib[3];
    body[0] = ^body[7:1];
  end
  assign cw = body;
endmodule

// File: rtl/ecc_ilv_dec.sv
module ecc_ilv_dec
  import ecc_ilv_pkg::*;
(
  input  cw_t  cw,
  output nib_t nib,
  output logic fixed_one,
  output logic double_err
);
  syn_t syn;
  logic par_bad;
  cw_t  repaired;
  always_comb begin
    syn[0]  = cw[1] ^ cw[3] ^ cw[5] ^ cw[7];
    syn[1]  = cw[2] ^ cw[3] ^ cw[6] ^ cw[7];
    syn[2]  = cw[4] ^ cw[5] ^ cw[6] ^ cw[7];
    par_bad = ^cw;
    repaired = cw;
    if (par_bad && (syn != '0))
      repaired[syn] = ~cw[syn];
  end
  assign nib        = {repaired[7], repaired[6], repaired[5], repaired[3]};
  assign fixed_one  = par_bad;
  assign double_err = !par_bad && (syn != '0);
endmodule

// File: rtl/ecc_ilv_map.sv
module ecc_ilv_map
  import ecc_ilv_pkg::*;
#(
  parameter int LANES = 2,
  localparam int WORD_W = LANES * CW_W
) (
  input  logic [LANES-1:0][CW_W-1:0] lanes_in,
  output logic [WORD_W-1:0]          word_out,
  input  logic [WORD_W-1:0]          word_in,
  output logic [LANES-1:0][CW_W-1:0] lanes_out
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < CW_W; k++) begin : g_bit
      assign word_out[LANES*k + l] = lanes_in[l][k];
      assign lanes_out[l][k]       = word_in[LANES*k + l];
    end
  end
endmodule

// File: rtl/ecc_ilv_array.sv
module ecc_ilv_array #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [WORD_W-1:0] inj_mask,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ce && we && (addr == AW'(i)))
          cells[i] <= wr_word ^ ((inj_en && (inj_addr == AW'(i))) ? inj_mask : '0);
        else if (inj_en && (inj_addr == AW'(i)))
          cells[i] <= cells[i] ^ inj_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_word  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= ce && !we;
      if (ce && !we) rd_word <= cells[addr];
    end
  end
endmodule

// File: rtl/ecc_ilv_mem.sv
module ecc_ilv_mem
  import ecc_ilv_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int DATA_W = LANES * NIB_W,
  localparam int WORD_W = LANES * CW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              rvalid,
  output logic              err_corrected,
  output logic              err_uncorrectable,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [WORD_W-1:0] inj_mask
);
  logic [LANES-1:0][CW_W-1:0] wr_lanes, rd_lanes;
  logic [WORD_W-1:0]          wr_word, rd_word;
  logic [LANES-1:0]           lane_fix, lane_dbl;

  for (genvar l = 0; l < LANES; l++) begin : g_codec
    ecc_ilv_enc enc_i (
      .nib (din[l*NIB_W +: NIB_W]),
      .cw  (wr_lanes[l])
    );
    ecc_ilv_dec dec_i (
      .cw         (rd_lanes[l]),
      .nib        (dout[l*NIB_W +: NIB_W]),
      .fixed_one  (lane_fix[l]),
      .double_err (lane_dbl[l])
    );
  end

  ecc_ilv_map #(.LANES(LANES)) map_i (
    .lanes_in  (wr_lanes),
    .word_out  (wr_word),
    .word_in   (rd_word),
    .lanes_out (rd_lanes)
  );

  ecc_ilv_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) array_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .we       (we),
    .addr     (addr),
    .wr_word  (wr_word),
    .inj_en   (inj_en),
    .inj_addr (inj_addr),
    .inj_mask (inj_mask),
    .rd_word  (rd_word),
    .rd_valid (rvalid)
  );

  assign err_corrected     = |lane_fix;
  assign err_uncorrectable = |lane_dbl;
endmodule

// File: rtl/ecc_ilv_mem_chk.sv
module ecc_ilv_mem_chk #(
  parameter int AW     = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              we,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              rvalid,
  input logic              err_corrected,
  input logic              err_uncorrectable,
  input logic              inj_en
);
  AST_RVALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !we) |=> rvalid); // R1
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && !we) |=> !rvalid); // R8
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && !we) |=> ($stable(dout) && $stable(err_corrected) && $stable(err_uncorrectable))); // R8
  AST_CLEAN_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && we && !inj_en) ##1 (ce && !we && !inj_en && addr == $past(addr))
    |=> (dout == $past(din, 2) && !err_corrected && !err_uncorrectable)); // R1
  AST_FLAG_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_corrected) || $rose(err_uncorrectable)) |-> rvalid); // R3
endmodule

bind ecc_ilv_mem ecc_ilv_mem_chk #(.AW(AW), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .din(din),
  .dout(dout), .rvalid(rvalid), .err_corrected(err_corrected),
  .err_uncorrectable(err_uncorrectable), .inj_en(inj_en)
);

// File: tb/ecc_ilv_mem_tb_top.sv
module ecc_ilv_mem_tb_top;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, ce = 0, we = 0, inj_en = 0;
  logic [AW-1:0] addr = '0, inj_addr = '0;
  logic [7:0] din = '0, dout;
  logic [15:0] inj_mask = '0;
  logic rvalid, err_c, err_u;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0]  m_byte [DEPTH];
  logic [15:0] m_mask [DEPTH];

  always #10 clk = ~clk;

  ecc_ilv_mem #(.DEPTH(DEPTH), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .din(din),
    .dout(dout), .rvalid(rvalid), .err_corrected(err_c),
    .err_uncorrectable(err_u), .inj_en(inj_en), .inj_addr(inj_addr),
    .inj_mask(inj_mask)
  );

  function automatic logic [7:0] b_enc(input logic [3:0] n);
    logic [7:0] c;
    c = '0;
    c[3] = n[0]; c[5] = n[1]; c[6] = n[2]; c[7] = n[3];
    c[1] = n[0] ^ n[1] ^ n[3];
    c[2] = n[0] ^ n[2] ^ n[3];
    c[4] = n[1] ^ n[2] ^ n[3];
    c[0] = ^c[7:1];
    return c;
  endfunction

  task automatic expect_of(input logic [7:0] d, input logic [15:0] m,
                           output logic [7:0] ed, output logic ec, output logic eu);
    ec = 0; eu = 0; ed = d;
    for (int l = 0; l < 2; l++) begin
      logic [7:0] lm, bad;
      for (int k = 0; k < 8; k++) lm[k] = m[2*k + l];
      bad = b_enc(d[4*l +: 4]) ^ lm;
      if ($countones(lm) == 2) begin
        eu = 1;
        ed[4*l +: 4] = {bad[7], bad[6], bad[5], bad[3]};
      end else if ($countones(lm) == 1) ec = 1;
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic [15:0] m = '0);
    @(negedge clk);
    ce = 1; we = 1; addr = a; din = d;
    inj_en = (m != 0); inj_addr = a; inj_mask = m;
    @(negedge clk);
    ce = 0; we = 0; inj_en = 0; inj_mask = '0;
    m_byte[a] = d; m_mask[a] = m;
  endtask

  task automatic inj(input logic [AW-1:0] a, input logic [15:0] m);
    @(negedge clk);
    inj_en = 1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 0; inj_mask = '0;
    m_mask[a] = m_mask[a] ^ m;
  endtask

  task automatic rd_check(input string tag, input logic [AW-1:0] a);
    logic [7:0] ed; logic ec, eu;
    @(negedge clk);
    ce = 1; we = 0; addr = a;
    @(negedge clk);
    ce = 0;
    expect_of(m_byte[a], m_mask[a], ed, ec, eu);
    chk({tag, " rvalid"}, int'(rvalid), 1);
    chk({tag, " data"}, int'(dout), int'(ed));
    chk({tag, " corr"}, int'(err_c), int'(ec));
    chk({tag, " uncorr"}, int'(err_u), int'(eu));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin m_byte[i] = 8'h00; m_mask[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rvalid", int'(rvalid), 0);
    chk("R9 dout", int'(dout), 0);
    chk("R9 flags", int'({err_c, err_u}), 0);
    rd_check("R9 read0", 4'd0);
    rd_check("R9 read15", 4'd15);

    // R1 / R2 directed patterns
    wr(4'd1, 8'h00); wr(4'd2, 8'hFF); wr(4'd3, 8'hA5); wr(4'd4, 8'h5A);
    rd_check("R1 00", 4'd1); rd_check("R1 FF", 4'd2);
    rd_check("R2 A5", 4'd3); rd_check("R2 5A", 4'd4);

    // R3 / R6 every single flip, R7 re-read
    for (int b = 0; b < 16; b++) begin
      wr(4'd6, 8'($urandom));
      inj(4'd6, 16'(1) << b);
      rd_check((b < 2) ? "R6 parity flip" : "R3 single flip", 4'd6);
      rd_check("R7 reread", 4'd6);
    end

    // R4 adjacent pairs
    for (int b = 0; b < 15; b++) begin
      wr(4'd7, 8'($urandom));
      inj(4'd7, 16'(3) << b);
      rd_check("R4 adjacent", 4'd7);
    end

    // R5 doubles inside one lane
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < 8; i++)
        for (int j = i + 1; j < 8; j++) begin
          wr(4'd8, 8'($urandom));
          inj(4'd8, (16'(1) << (2*i + l)) | (16'(1) << (2*j + l)));
          rd_check("R5 double", 4'd8);
        end

    // R10 injection concurrent with write
    wr(4'd9, 8'h3C, 16'h0100);
    rd_check("R10 write+inj", 4'd9);

    // R11 write with ce low
    wr(4'd10, 8'h77);
    @(negedge clk); ce = 0; we = 1; addr = 4'd10; din = 8'h11;
    @(negedge clk); we = 0;
    rd_check("R11 ce low", 4'd10);

    // R8 hold after non-read cycles
    rd_check("R8 setup", 4'd2);
    held = dout;
    wr(4'd2, 8'h42);
    chk("R8 rvalid", int'(rvalid), 0);
    chk("R8 dout hold", int'(dout), int'(held));

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a; int op;
      a = AW'($urandom_range(0, DEPTH - 1));
      op = $urandom_range(0, 3);
      if (op == 0) wr(a, 8'($urandom));
      else if (op == 1 && m_mask[a] == 0) begin
        if ($urandom_range(0, 1) == 1) inj(a, 16'(1) << $urandom_range(0, 15));
        else inj(a, 16'(3) << $urandom_range(0, 14));
      end else rd_check("R3 random", a);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule